// File: doc/BRIEF.md
# Debug Command Execution Engine

This block executes debug commands that an upstream serial front end has already decoded. A command arrives over a valid/ready handshake as an opcode, an access size, a register selector, a 32-bit address and a 32-bit operand. The engine runs it against a small register file or a bus master. It returns one response per command over a second valid/ready handshake. Each response carries a status and 32 bits of result.

Memory commands drive a single-beat bus with an address-space code. Reads take that code from a source space register and writes take it from a destination space register. Two streaming commands, dump and fill, carry no address. Each continues from a pointer that the last good read or write set up, and advances it by the access size. A peripheral reset command pulses a reset output for a fixed number of cycles and leaves the engine's own state alone. The engine takes one command at a time.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset, cmd_ready is 1 and rsp_valid, bus_req and periph_rst are 0.
- R2: Register read (opcode 1) returns the last value written by register write (opcode 2) to the same cmd_sel index. Indices 0-7 are data registers and 8-15 are address registers. Every register resets to 0. Status OK is 0, and a write responds OK with data 0.
- R3: System register read (opcode 3) and write (opcode 4) use cmd_sel[1:0]. Index 0 is the 3-bit source space code and index 1 is the 3-bit destination space code; both read back zero-extended. Indices 2 and 3 are 32-bit scratch registers.
- R4: Memory read (opcode 5) raises bus_req with bus_we 0, bus_addr equal to cmd_addr, bus_size equal to cmd_size and bus_fc equal to the source space code. Size 0 is byte, 1 is word and 2 is long. The response holds bus_rdata masked to the low 8, 16 or 32 bits.
- R5: Memory write (opcode 6) raises bus_req with bus_we 1, bus_fc equal to the destination space code and bus_wdata equal to cmd_data. It responds OK with data 0.
- R6: Dump (opcode 7) ignores cmd_addr. It reads at the previous good read or dump address plus that access's byte count, using its own size, and then advances the pointer the same way.
- R7: Fill (opcode 8) ignores cmd_addr. It writes cmd_data at the previous good write or fill address plus that access's byte count, and advances the pointer the same way.
- R8: A dump before any good read, or a fill before any good write, returns status 2 (illegal) with data 0 and no bus access.
- R9: While bus_req is high, the address and controls hold until bus_ack or bus_err. bus_err returns status 1 with data 0 and leaves the block pointer unchanged. bus_err wins over bus_ack.
- R10: Peripheral reset (opcode 9) holds periph_rst high for exactly 512 cycles and then responds OK. cmd_ready is low throughout, and register contents are unchanged.
- R11: No-operation (opcode 0) responds OK with data 0 and makes no bus access.
- R12: cmd_ready is low from acceptance until the response is taken. rsp_valid, rsp_status and rsp_data hold steady while rsp_ready is low.
- R13: Opcodes 10-15, and any memory, dump or fill command with size 3, return status 2 with no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can accept a command |
| cmd_op | input | 4 | Opcode |
| cmd_size | input | 2 | Access size: 0 byte, 1 word, 2 long |
| cmd_sel | input | 4 | Register selector |
| cmd_addr | input | 32 | Memory address |
| cmd_data | input | 32 | Operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_status | output | 2 | 0 OK, 1 bus error, 2 illegal |
| rsp_data | output | 32 | Result data |
| bus_req | output | 1 | Bus access in progress |
| bus_we | output | 1 | 1 for write |
| bus_addr | output | 32 | Bus address |
| bus_fc | output | 3 | Address-space code |
| bus_size | output | 2 | Access size |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, right-justified |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed |
| periph_rst | output | 1 | Peripheral reset pulse |

## Verification
- Register, no-operation and illegal commands raise rsp_valid in the cycle after acceptance.
- A bus command raises bus_req in the cycle after acceptance, and its response appears in the cycle after bus_ack or bus_err is sampled.
- A peripheral reset responds in the cycle after its 512th reset cycle.
- Inputs change and outputs are sampled on the falling edge. The scoreboard pops an expected response only in a cycle where rsp_valid and rsp_ready are both high, so every response is compared exactly once, and a response that arrives early or late shows up as a mismatch or as a leftover queue entry.
- Bus fields are captured while bus_req is high, and periph_rst cycles are counted on their own, so those results are checked outside the response path.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_RREG = 4'd1;
  localparam logic [3:0] OP_WREG = 4'd2;
  localparam logic [3:0] OP_RSYS = 4'd3;
  localparam logic [3:0] OP_WSYS = 4'd4;
  localparam logic [3:0] OP_MRD  = 4'd5;
  localparam logic [3:0] OP_MWR  = 4'd6;
  localparam logic [3:0] OP_DUMP = 4'd7;
  localparam logic [3:0] OP_FILL = 4'd8;
  localparam logic [3:0] OP_PRST = 4'd9;

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_BERR = 2'd1;
  localparam logic [1:0] ST_ILL  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RST, S_RESP} eng_state_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = {24'd0, d[7:0]};
      2'd1:    size_mask = {16'd0, d[15:0]};
      default: size_mask = d;
    endcase
  endfunction
endpackage

// File: rtl/dbg_regfile.sv
module dbg_regfile #(
  parameter int SELW = 4,
  parameter int DW   = 32,
  parameter int FCW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel,
  input  logic            gp_we,
  input  logic            sys_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   gp_rdata,
  output logic [DW-1:0]   sys_rdata,
  output logic [FCW-1:0]  src_fc,
  output logic [FCW-1:0]  dst_fc
);
  localparam int NREG = 1 << SELW;

  logic [DW-1:0]  gp_q [NREG];
  logic [DW-1:0]  scr_q [2];
  logic [FCW-1:0] sfc_q, dfc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gp_q[i] <= '0;
    end else if (gp_we) begin
      gp_q[sel] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sfc_q    <= '0;
      dfc_q    <= '0;
      scr_q[0] <= '0;
      scr_q[1] <= '0;
    end else if (sys_we) begin
      case (sel[1:0])
        2'd0:    sfc_q    <= wdata[FCW-1:0];
        2'd1:    dfc_q    <= wdata[FCW-1:0];
        2'd2:    scr_q[0] <= wdata;
        default: scr_q[1] <= wdata;
      endcase
    end
  end

  always_comb begin
    gp_rdata = gp_q[sel];
    case (sel[1:0])
      2'd0:    sys_rdata = DW'(sfc_q);
      2'd1:    sys_rdata = DW'(dfc_q);
      2'd2:    sys_rdata = scr_q[0];
      default: sys_rdata = scr_q[1];
    endcase
  end

  assign src_fc = sfc_q;
  assign dst_fc = dfc_q;

  // R3
  fc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_we |=> $stable(src_fc) && $stable(dst_fc));
endmodule

// File: rtl/dbg_blk_ptr.sv
module dbg_blk_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] ptr,
  output logic          vld
);
  logic [AW-1:0] ptr_q;
  logic          vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= 1'b0;
    end else if (load) begin
      ptr_q <= load_val;
      vld_q <= 1'b1;
    end
  end

  assign ptr = ptr_q;
  assign vld = vld_q;

  // R8
  vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> vld);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ptr));
endmodule

// File: rtl/dbg_rst_timer.sv
module dbg_rst_timer #(
  parameter int CYCLES = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      cnt_d  = CW'(CYCLES - 1);
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // R10
  rst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (cnt_q == CW'(CYCLES - 1)));
  // R10
  rst_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int FCW        = 3,
  parameter int SELW       = 4,
  parameter int RST_CYCLES = 512
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [3:0]      cmd_op,
  input  logic [1:0]      cmd_size,
  input  logic [SELW-1:0] cmd_sel,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_status,
  output logic [DW-1:0]   rsp_data,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [FCW-1:0]  bus_fc,
  output logic [1:0]      bus_size,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_ack,
  input  logic            bus_err,
  output logic            periph_rst
);
  import dbg_pkg::*;

  eng_state_e     state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic           we_q, we_d;
  logic [FCW-1:0] fc_q, fc_d;
  logic [1:0]     size_q, size_d;
  logic [DW-1:0]  wdata_q, wdata_d;
  logic [1:0]     stat_q, stat_d;
  logic [DW-1:0]  rdat_q, rdat_d;

  logic           gp_we, sys_we, tmr_start, tmr_busy, tmr_done;
  logic [DW-1:0]  gp_rdata, sys_rdata;
  logic [FCW-1:0] src_fc, dst_fc;
  logic           rd_load, wr_load, rd_vld, wr_vld;
  logic [AW-1:0]  rd_ptr, wr_ptr, next_addr;
  logic           accept, size_ok;

  assign accept    = cmd_valid && cmd_ready;
  assign size_ok   = (cmd_size != 2'd3);
  assign next_addr = addr_q + AW'(size_bytes(size_q));

  dbg_regfile #(.SELW(SELW), .DW(DW), .FCW(FCW)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(cmd_sel), .gp_we(gp_we), .sys_we(sys_we),
    .wdata(cmd_data), .gp_rdata(gp_rdata), .sys_rdata(sys_rdata),
    .src_fc(src_fc), .dst_fc(dst_fc));

  dbg_blk_ptr #(.AW(AW)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(next_addr),
    .ptr(rd_ptr), .vld(rd_vld));

  dbg_blk_ptr #(.AW(AW)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .load_val(next_addr),
    .ptr(wr_ptr), .vld(wr_vld));

  dbg_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(tmr_busy), .done(tmr_done));

  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    we_d      = we_q;
    fc_d      = fc_q;
    size_d    = size_q;
    wdata_d   = wdata_q;
    stat_d    = stat_q;
    rdat_d    = rdat_q;
    gp_we     = 1'b0;
    sys_we    = 1'b0;
    tmr_start = 1'b0;
    rd_load   = 1'b0;
    wr_load   = 1'b0;
    case (state_q)
      S_IDLE: if (accept) begin
        state_d = S_RESP;
        stat_d  = ST_OK;
        rdat_d  = '0;
        size_d  = cmd_size;
        wdata_d = cmd_data;
        case (cmd_op)
          OP_NOP:  ;
          OP_RREG: rdat_d = gp_rdata;
          OP_WREG: gp_we  = 1'b1;
          OP_RSYS: rdat_d = sys_rdata;
          OP_WSYS: sys_we = 1'b1;
          OP_MRD, OP_DUMP: begin
            if (size_ok && (cmd_op == OP_MRD || rd_vld)) begin
              state_d = S_BUS;
              we_d    = 1'b0;
              fc_d    = src_fc;
              addr_d  = (cmd_op == OP_MRD) ? cmd_addr : rd_ptr;
            end else begin
              stat_d = ST_ILL;
            end
          end
          OP_MWR, OP_FILL: begin
            if (size_ok && (cmd_op == OP_MWR || wr_vld)) begin
              state_d = S_BUS;
              we_d    = 1'b1;
              fc_d    = dst_fc;
              addr_d  = (cmd_op == OP_MWR) ? cmd_addr : wr_ptr;
            end else begin
              stat_d = ST_ILL;
            end
          end
          OP_PRST: begin
            tmr_start = 1'b1;
            state_d   = S_RST;
          end
          default: stat_d = ST_ILL;
        endcase
      end
      S_BUS: begin
        if (bus_err) begin
          stat_d  = ST_BERR;
          rdat_d  = '0;
          state_d = S_RESP;
        end else if (bus_ack) begin
          stat_d  = ST_OK;
          rdat_d  = we_q ? '0 : size_mask(bus_rdata, size_q);
          rd_load = !we_q;
          wr_load = we_q;
          state_d = S_RESP;
        end
      end
      S_RST:  if (tmr_done) state_d = S_RESP;
      S_RESP: if (rsp_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      fc_q    <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      stat_q  <= ST_OK;
      rdat_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      we_q    <= we_d;
      fc_q    <= fc_d;
      size_q  <= size_d;
      wdata_q <= wdata_d;
      stat_q  <= stat_d;
      rdat_q  <= rdat_d;
    end
  end

  assign cmd_ready  = (state_q == S_IDLE);
  assign rsp_valid  = (state_q == S_RESP);
  assign rsp_status = stat_q;
  assign rsp_data   = rdat_q;
  assign bus_req    = (state_q == S_BUS);
  assign bus_we     = we_q;
  assign bus_addr   = addr_q;
  assign bus_fc     = fc_q;
  assign bus_size   = size_q;
  assign bus_wdata  = wdata_q;
  assign periph_rst = tmr_busy;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rsp_valid && !bus_req && !periph_rst);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));
  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_fc));
  // R10
  prst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst |-> !cmd_ready && !bus_req);
  // R8
  dump_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_op == OP_DUMP && !rd_vld |=> !bus_req && rsp_valid && rsp_status == ST_ILL);
  // R9
  berr_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> rsp_valid && rsp_status == ST_BERR);
endmodule

// File: tb/dbg_cmd_engine_tb.sv
module dbg_cmd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready;
  logic [3:0]  cmd_op, cmd_sel;
  logic [1:0]  cmd_size;
  logic [31:0] cmd_addr, cmd_data;
  logic        rsp_valid, rsp_ready;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_data;
  logic        bus_req, bus_we, bus_ack, bus_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  bus_fc;
  logic [1:0]  bus_size;
  logic        periph_rst;

  dbg_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_size(cmd_size), .cmd_sel(cmd_sel), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err), .periph_rst(periph_rst));

  typedef struct {
    logic [1:0]  st;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  int bus_cnt = 0;
  int prst_cnt = 0;
  int ready_viol = 0;
  logic        inj_err;
  logic        prev_req;
  int          wait_c;
  logic [31:0] l_addr, l_wdata;
  logic [2:0]  l_fc;
  logic        l_we;
  logic [1:0]  l_size;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return a ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] mask(input logic [31:0] d, input logic [1:0] s);
    if (s == 2'd0) return {24'd0, d[7:0]};
    if (s == 2'd1) return {16'd0, d[15:0]};
    return d;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus responder and recorder
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
      wait_c <= 0; prev_req <= 1'b0;
    end else begin
      prev_req <= bus_req;
      if (bus_req && !prev_req) bus_cnt++;
      if (bus_req) begin
        l_addr = bus_addr; l_wdata = bus_wdata; l_fc = bus_fc;
        l_we = bus_we; l_size = bus_size;
      end
      if (bus_ack || bus_err) begin
        bus_ack <= 1'b0; bus_err <= 1'b0; wait_c <= 0;
      end else if (bus_req) begin
        if (wait_c == 1) begin
          if (inj_err) bus_err <= 1'b1;
          else         bus_ack <= 1'b1;
          bus_rdata <= mem_model(bus_addr);
        end else begin
          wait_c <= wait_c + 1;
        end
      end
      if (periph_rst) prst_cnt++;
      if (periph_rst && cmd_ready) ready_viol++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R12 unexpected response", rsp_data, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_status == e.st, {e.tag, " status"}, 32'(rsp_status), 32'(e.st));
        chk(rsp_data == e.data, {e.tag, " data"}, rsp_data, e.data);
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] sz, input logic [3:0] sel,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic [1:0] es, input logic [31:0] ed, input string tag,
                       input bit wait_rsp);
    exp_t e;
    e.st = es; e.data = ed; e.tag = tag;
    while (!cmd_ready) @(negedge clk);
    sb_q.push_back(e);
    cmd_valid = 1'b1; cmd_op = op; cmd_size = sz; cmd_sel = sel;
    cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wait_rsp) begin
      while (sb_q.size() != 0) @(negedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_size = '0; cmd_sel = '0;
    cmd_addr = '0; cmd_data = '0; rsp_ready = 1'b1; inj_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !rsp_valid && !bus_req && !periph_rst, "R1 reset outputs",
        {28'd0, cmd_ready, rsp_valid, bus_req, periph_rst}, 32'h8);

    // R2 register file
    issue(4'd2, 2'd2, 4'd3,  32'h0, 32'h1122_3344, 2'd0, 32'h0, "R2 write d3", 1);
    issue(4'd2, 2'd2, 4'd12, 32'h0, 32'hCAFE_0012, 2'd0, 32'h0, "R2 write a4", 1);
    issue(4'd1, 2'd2, 4'd3,  32'h0, 32'h0, 2'd0, 32'h1122_3344, "R2 read d3", 1);
    issue(4'd1, 2'd2, 4'd12, 32'h0, 32'h0, 2'd0, 32'hCAFE_0012, "R2 read a4", 1);
    issue(4'd1, 2'd2, 4'd5,  32'h0, 32'h0, 2'd0, 32'h0, "R2 read unwritten", 1);

    // R3 system registers
    issue(4'd4, 2'd2, 4'd0, 32'h0, 32'hFFFF_FFFE, 2'd0, 32'h0, "R3 write src", 1);
    issue(4'd4, 2'd2, 4'd1, 32'h0, 32'h0000_0003, 2'd0, 32'h0, "R3 write dst", 1);
    issue(4'd4, 2'd2, 4'd2, 32'h0, 32'hDEAD_BEEF, 2'd0, 32'h0, "R3 write scratch", 1);
    issue(4'd3, 2'd2, 4'd0, 32'h0, 32'h0, 2'd0, 32'h6, "R3 read src", 1);
    issue(4'd3, 2'd2, 4'd1, 32'h0, 32'h0, 2'd0, 32'h3, "R3 read dst", 1);
    issue(4'd3, 2'd2, 4'd2, 32'h0, 32'h0, 2'd0, 32'hDEAD_BEEF, "R3 read scratch", 1);

    // R8 streaming before setup
    b0 = bus_cnt;
    issue(4'd7, 2'd2, 4'd0, 32'h0, 32'h0, 2'd2, 32'h0, "R8 early dump", 1);
    issue(4'd8, 2'd2, 4'd0, 32'h0, 32'h1, 2'd2, 32'h0, "R8 early fill", 1);
    chk(bus_cnt == b0, "R8 no bus access", 32'(bus_cnt), 32'(b0));

    // R4 memory read
    issue(4'd5, 2'd2, 4'd0, 32'h1000_0000, 32'h0, 2'd0, mem_model(32'h1000_0000), "R4 read long", 1);
    chk(l_addr == 32'h1000_0000 && !l_we && l_fc == 3'd6 && l_size == 2'd2,
        "R4 bus fields", l_addr, 32'h1000_0000);
    issue(4'd5, 2'd0, 4'd0, 32'h2001, 32'h0, 2'd0, mask(mem_model(32'h2001), 2'd0), "R4 read byte", 1);

    // R6 dump
    issue(4'd7, 2'd1, 4'd0, 32'hFFFF_0000, 32'h0, 2'd0, mask(mem_model(32'h2002), 2'd1), "R6 dump word", 1);
    chk(l_addr == 32'h2002 && l_fc == 3'd6, "R6 dump addr 1", l_addr, 32'h2002);
    issue(4'd7, 2'd2, 4'd0, 32'h0, 32'h0, 2'd0, mem_model(32'h2004), "R6 dump long", 1);
    chk(l_addr == 32'h2004, "R6 dump addr 2", l_addr, 32'h2004);

    // R5 memory write
    issue(4'd6, 2'd1, 4'd0, 32'h3000, 32'hAAAA_5555, 2'd0, 32'h0, "R5 write word", 1);
    chk(l_addr == 32'h3000 && l_we && l_fc == 3'd3 && l_wdata == 32'hAAAA_5555 && l_size == 2'd1,
        "R5 bus fields", l_wdata, 32'hAAAA_5555);

    // R7 fill
    issue(4'd8, 2'd2, 4'd0, 32'h9999_0000, 32'h0102_0304, 2'd0, 32'h0, "R7 fill long", 1);
    chk(l_addr == 32'h3002 && l_we && l_wdata == 32'h0102_0304, "R7 fill addr 1", l_addr, 32'h3002);
    issue(4'd8, 2'd0, 4'd0, 32'h0, 32'h0000_00EE, 2'd0, 32'h0, "R7 fill byte", 1);
    chk(l_addr == 32'h3006 && l_fc == 3'd3, "R7 fill addr 2", l_addr, 32'h3006);

    // R9 bus error
    inj_err = 1'b1;
    issue(4'd5, 2'd2, 4'd0, 32'h4000, 32'h0, 2'd1, 32'h0, "R9 read error", 1);
    inj_err = 1'b0;
    issue(4'd7, 2'd2, 4'd0, 32'h0, 32'h0, 2'd0, mem_model(32'h2008), "R9 dump after error", 1);
    chk(l_addr == 32'h2008, "R9 pointer kept", l_addr, 32'h2008);

    // R10 peripheral reset
    prst_cnt = 0; ready_viol = 0;
    issue(4'd9, 2'd0, 4'd0, 32'h0, 32'h0, 2'd0, 32'h0, "R10 reset response", 1);
    chk(prst_cnt == 512, "R10 pulse length", 32'(prst_cnt), 32'd512);
    chk(ready_viol == 0, "R10 ready low", 32'(ready_viol), 32'd0);
    issue(4'd1, 2'd2, 4'd3, 32'h0, 32'h0, 2'd0, 32'h1122_3344, "R10 regs kept", 1);

    // R11 no-operation
    b0 = bus_cnt;
    issue(4'd0, 2'd2, 4'd7, 32'h5000, 32'h1234, 2'd0, 32'h0, "R11 nop", 1);
    chk(bus_cnt == b0, "R11 no bus", 32'(bus_cnt), 32'(b0));
    issue(4'd3, 2'd2, 4'd2, 32'h0, 32'h0, 2'd0, 32'hDEAD_BEEF, "R11 state kept", 1);

    // R12 response back-pressure
    rsp_ready = 1'b0;
    issue(4'd1, 2'd2, 4'd12, 32'h0, 32'h0, 2'd0, 32'hCAFE_0012, "R12 held read", 0);
    repeat (3) @(negedge clk);
    chk(rsp_valid && !cmd_ready && rsp_data == 32'hCAFE_0012, "R12 hold", rsp_data, 32'hCAFE_0012);
    rsp_ready = 1'b1;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);

    // R13 illegal
    b0 = bus_cnt;
    issue(4'd13, 2'd2, 4'd0, 32'h0, 32'h0, 2'd2, 32'h0, "R13 bad opcode", 1);
    issue(4'd5, 2'd3, 4'd0, 32'h6000, 32'h0, 2'd2, 32'h0, "R13 bad size", 1);
    chk(bus_cnt == b0, "R13 no bus", 32'(bus_cnt), 32'(b0));

    chk(sb_q.size() == 0, "R12 scoreboard drained", 32'(sb_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule